// File: doc/BRIEF.md
# Shared-Interval Input Deglitch Filter

This block cleans a wide bus of digital inputs of short glitches. Every channel sits behind one shared stability interval held in a single register, and each channel has its own bit that switches filtering on or off. A filtered channel moves its output to a new level only after the raw input has differed from the output for a set number of consecutive sample ticks. An unfiltered channel copies its input to the output one clock later.

Channels come in ports of eight. Each port has one enable register with one bit per channel. A `tick_en` strobe supplies the sample timebase, which is usually one pulse per 200 ns. All counting is done in units of that strobe, so the clock rate does not enter into it. After reset the interval and all enables are zero, which leaves every channel unfiltered.

Register writes go over a simple single-cycle bus. The read data comes out registered, one clock after the address is presented.

Top module: `dgf_top`

## Requirements
- R1: After reset the interval register reads 0, every enable register reads 0, and every channel is unfiltered.
- R2: A write to address 0x08 stores bits 19:0 of the write data as the interval and drops bits 31:20. A read of 0x08 returns the stored interval zero-extended to 32 bits.
- R3: Port p has its enable register at address 0x40 + 16*p + 4, with bit i enabling channel 8*p + i. Writes store wdata[7:0] and reads return them in rdata[7:0] with bits 31:8 zero. Reads of any other address return 0. Read data appears one clock after the address.
- R4: For a channel whose enable bit is clear, clean_out equals raw_in as sampled at the previous clock edge, whether or not a tick is present.
- R5: With interval N ≥ 1, an enabled channel's output takes the raw level at the N-th consecutive tick on which the raw input differs from the output. Fewer ticks leave it unchanged. This applies to rising and falling changes alike.
- R6: If the raw input of an enabled channel equals its output on any clock before the N-th tick, the tick count restarts, so a pulse shorter than N ticks never reaches the output.
- R7: An enabled channel's output changes only on a clock that carries a tick, and only to the raw level sampled at that clock.
- R8: With the interval set to 0, an enabled channel's output takes a differing raw level at the first tick.
- R9: Clearing a channel's enable bit makes its output equal the raw input by the second clock edge after the write, without waiting for a tick. Its tick count is discarded.
- R10: A new interval value applies to every enabled channel in every port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe, one clock per write |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| tick_en | input | 1 | Sample tick, counts one interval unit |
| raw_in | input | 8*NUM_PORTS | Raw input channels, synchronous to clk |
| clean_out | output | 8*NUM_PORTS | Filtered output channels, registered |

## Verification
The assertions take raw_in, tick_en and the register bus to be synchronous to clk and free of unknown values from the first clock after reset. The output-hold and follow properties rely on that. They also assume the register address is stable for the cycle its read is taken. The bench drives every input at the falling edge from reset onward, holds raw_in at zero during reset, and issues ticks as single-cycle pulses. This lets it count the exact tick at which each filtered channel must change.

// File: rtl/dgf_pkg.sv
package dgf_pkg;
  localparam int REG_W      = 32;
  localparam int INTERVAL_W = 20;
  localparam int PORT_W     = 8;

  localparam int ADDR_INTERVAL = 'h08;
  localparam int PORT_BASE     = 'h40;
  localparam int PORT_STRIDE   = 'h10;
  localparam int ENA_OFFSET    = 'h4;

  typedef logic [INTERVAL_W-1:0] interval_t;

  function automatic int ena_addr(input int port);
    return PORT_BASE + port * PORT_STRIDE + ENA_OFFSET;
  endfunction
endpackage

// File: rtl/dgf_regs.sv
module dgf_regs
  import dgf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int CH       = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output interval_t         interval,
  output logic [CH-1:0]     en_vec
);
  logic [PORT_W-1:0] ena_q [NUM_PORTS];
  logic [REG_W-1:0]  rd_next;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[REG_W-1:INTERVAL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      interval <= '0;
    end else if (wr_en && addr == ADDR_W'(ADDR_INTERVAL)) begin
      interval <= wdata[INTERVAL_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ena_addr(p));
    always_ff @(posedge clk) begin
      if (rst) begin
        ena_q[p] <= '0;
      end else if (wr_en && addr == MY_ADDR) begin
        ena_q[p] <= wdata[PORT_W-1:0];
      end
    end
    assign en_vec[p*PORT_W +: PORT_W] = ena_q[p];
  end

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADDR_INTERVAL)) begin
      rd_next = REG_W'(interval);
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (addr == ADDR_W'(ena_addr(p))) begin
        rd_next = REG_W'(ena_q[p]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/dgf_chan.sv
module dgf_chan
  import dgf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      tick,
  input  interval_t interval,
  input  logic      raw,
  output logic      out
);
  interval_t             cnt;
  logic [INTERVAL_W:0]   cnt_inc;
  logic                  reached;

  assign cnt_inc = {1'b0, cnt} + 1'b1;
  assign reached = cnt_inc >= {1'b0, interval};

  always_ff @(posedge clk) begin
    if (rst) begin
      out <= 1'b0;
      cnt <= '0;
    end else if (!en) begin
      out <= raw;
      cnt <= '0;
    end else if (raw == out) begin
      cnt <= '0;
    end else if (tick) begin
      if (reached) begin
        out <= raw;
        cnt <= '0;
      end else begin
        cnt <= cnt_inc[INTERVAL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dgf_top.sv
module dgf_top
  import dgf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int CH       = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              tick_en,
  input  logic [CH-1:0]     raw_in,
  output logic [CH-1:0]     clean_out
);
  interval_t       interval;
  logic [CH-1:0]   en_vec;

  dgf_regs #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .interval(interval),
    .en_vec  (en_vec)
  );

  for (genvar c = 0; c < CH; c++) begin : g_chan
    dgf_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .en      (en_vec[c]),
      .tick    (tick_en),
      .interval(interval),
      .raw     (raw_in[c]),
      .out     (clean_out[c])
    );
  end
endmodule

// File: rtl/dgf_chk.sv
module dgf_chk
  import dgf_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W    = 8,
  localparam int CH       = NUM_PORTS * PORT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [CH-1:0]     raw,
  input logic [CH-1:0]     out,
  input logic [CH-1:0]     en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       rdata
);
  // R4
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~$past(en)) & (out ^ $past(raw))) == '0);

  // R7
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(tick)) |-> ((out ^ $past(out)) & $past(en)) == '0);

  // R5
  change_to_raw_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((out ^ $past(out)) & $past(en) & (out ^ $past(raw))) == '0);

  // R2
  interval_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr) == ADDR_W'(ADDR_INTERVAL)) |-> rdata[31:INTERVAL_W] == '0);

  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr[3:0]) != 4'h4 && $past(addr) != ADDR_W'(ADDR_INTERVAL))
      |-> rdata == '0);

  // R3
  enable_width_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(addr[3:0]) == 4'h4) |-> rdata[31:PORT_W] == '0);
endmodule

bind dgf_top dgf_chk #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .tick (tick_en),
  .raw  (raw_in),
  .out  (clean_out),
  .en   (en_vec),
  .addr (reg_addr),
  .rdata(reg_rdata)
);

// File: tb/tb_dgf_top.sv
`timescale 1ns/1ps
module tb_dgf_top;
  localparam int NP = 4;
  localparam int AW = 8;
  localparam int CH = NP * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          tick_en = 1'b0;
  logic [CH-1:0] raw_in = '0;
  logic [CH-1:0] clean_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #4 clk = ~clk;

  dgf_top #(.NUM_PORTS(NP), .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en),
    .raw_in(raw_in), .clean_out(clean_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic set_raw(input int ch, input logic v);
    @(negedge clk);
    raw_in[ch] = v;
  endtask

  task automatic t_reset;
    rd_check("R1 interval", 8'h08, 32'h0);
    for (int p = 0; p < NP; p++) rd_check("R1 enable", AW'(8'h44 + p*16), 32'h0);
    check("R1 outputs", 32'(clean_out), 32'h0);
    set_raw(9, 1'b1);
    @(negedge clk);
    check("R1 bypass", 32'(clean_out[9]), 32'h1);
    set_raw(9, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_regs;
    wr(8'h08, 32'hFFF1_2345);
    rd_check("R2 interval trunc", 8'h08, 32'h0001_2345);
    wr(8'h64, 32'h0000_01A5);
    rd_check("R3 enable port2", 8'h64, 32'h0000_00A5);
    rd_check("R3 neighbour addr", 8'h65, 32'h0);
    rd_check("R3 port base", 8'h40, 32'h0);
    rd_check("R3 port0 untouched", 8'h44, 32'h0);
    wr(8'h64, 32'h0);
    wr(8'h08, 32'h0);
    rd_check("R2 interval clear", 8'h08, 32'h0);
  endtask

  task automatic t_filter;
    wr(8'h08, 32'd3);
    wr(8'h44, 32'h01);
    set_raw(0, 1'b1);
    ticks(2);
    check("R5 rise before N", 32'(clean_out[0]), 32'h0);
    ticks(1);
    check("R5 rise at N", 32'(clean_out[0]), 32'h1);
    set_raw(0, 1'b0);
    ticks(2);
    check("R5 fall before N", 32'(clean_out[0]), 32'h1);
    ticks(1);
    check("R5 fall at N", 32'(clean_out[0]), 32'h0);
  endtask

  task automatic t_glitch;
    set_raw(0, 1'b1);
    ticks(2);
    set_raw(0, 1'b0);
    set_raw(0, 1'b1);
    ticks(2);
    check("R6 restart after glitch", 32'(clean_out[0]), 32'h0);
    ticks(1);
    check("R6 full run passes", 32'(clean_out[0]), 32'h1);
    set_raw(0, 1'b0);
    ticks(3);
    check("R6 restore", 32'(clean_out[0]), 32'h0);
  endtask

  task automatic t_no_tick;
    set_raw(0, 1'b1);
    repeat (50) @(negedge clk);
    check("R7 hold without tick", 32'(clean_out[0]), 32'h0);
    ticks(3);
    check("R7 moves with ticks", 32'(clean_out[0]), 32'h1);
    set_raw(0, 1'b0);
    ticks(3);
  endtask

  task automatic t_zero_interval;
    wr(8'h08, 32'd0);
    set_raw(0, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 waits for tick", 32'(clean_out[0]), 32'h0);
    ticks(1);
    check("R8 first tick", 32'(clean_out[0]), 32'h1);
  endtask

  task automatic t_bypass;
    set_raw(5, 1'b1);
    @(negedge clk);
    check("R4 unfiltered rise", 32'(clean_out[5]), 32'h1);
    set_raw(5, 1'b0);
    @(negedge clk);
    check("R4 unfiltered fall", 32'(clean_out[5]), 32'h0);
  endtask

  task automatic t_disable;
    wr(8'h08, 32'd3);
    set_raw(0, 1'b0);
    ticks(2);
    check("R9 still filtered", 32'(clean_out[0]), 32'h1);
    wr(8'h44, 32'h00);
    @(negedge clk);
    check("R9 follows after clear", 32'(clean_out[0]), 32'h0);
  endtask

  task automatic t_global;
    wr(8'h08, 32'd2);
    wr(8'h44, 32'h01);
    wr(8'h74, 32'h01);
    @(negedge clk);
    raw_in[0] = 1'b1; raw_in[24] = 1'b1;
    ticks(1);
    check("R10 two ports before", 32'({clean_out[24], clean_out[0]}), 32'h0);
    ticks(1);
    check("R10 two ports at 2", 32'({clean_out[24], clean_out[0]}), 32'h3);
    wr(8'h08, 32'd4);
    @(negedge clk);
    raw_in[0] = 1'b0; raw_in[24] = 1'b0;
    ticks(3);
    check("R10 new interval before", 32'({clean_out[24], clean_out[0]}), 32'h3);
    ticks(1);
    check("R10 new interval at 4", 32'({clean_out[24], clean_out[0]}), 32'h0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #400_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_filter();
    t_glitch();
    t_no_tick();
    t_zero_interval();
    t_bypass();
    t_disable();
    t_global();
    finish_run();
  end
endmodule